// File: doc/BRIEF.md
# Inverter Protection Fault Controller

This block supervises the gate commands of a three-phase, six-switch inverter bridge. Six active-high PWM commands, one per switch, come in, and six gate enables go out. Between them the block applies the protection rules. A short circuit or a loss of the low-side driver supply shuts down every switch. A loss of one high-side bootstrap bias shuts down only that phase's upper switch. An external controller can pull the shared fault line low to stop everything.

All fault conditions arrive as digital flags that have already been filtered. Every asynchronous input passes through two flip-flop stages before use. Each command must stay high for a minimum number of cycles before it counts, so short glitches are dropped. The block drives an active-low open-drain fault line through `flt_drv_o`, where 1 means pull the line low. It reads that line back on `flt_sense_i`. Its own drive, and the two cycles of synchroniser lag that follow it, are masked out, so the block never treats its own fault pulse as an external shutdown.

After any condition that removed a gate, the gate stays off until its command shows a fresh qualified rising edge. A command level that was held through the fault never turns the switch back on.

Top module: `inv_prot_ctrl`

## Requirements
- R1: A high `sc_i` forces all six gate outputs low by the third rising clock edge after it rises, whatever the commands are.
- R2: A short-circuit event holds `flt_drv_o` high for exactly FAULT_PULSE_CYC cycles when `sc_i` clears before then. While `sc_i` stays high, the pulse is extended, and it ends within a few cycles after `sc_i` falls.
- R3: In every cycle where `flt_drv_o` is high, all gate outputs are low, even with every command held high.
- R4: While `uv_lo_i` is high, all gates are off and `flt_drv_o` is high. When `uv_lo_i` falls, `flt_drv_o` is released within four cycles.
- R5: A high `uv_hi_i[n]` turns off only `gate_hi_o[n]`. The other gates keep following their commands, and `flt_drv_o` stays low.
- R6: After a short circuit, a low-side undervoltage, a high-side undervoltage or an external shutdown ends, a gate turns on again only after a new rising edge on its own command. A command held high through the condition keeps the gate off.
- R7: When `flt_sense_i` is pulled low by something other than the block's own drive, all gates turn off. The block's own fault pulse does not register as an external shutdown, so `flt_drv_o` falls back low after a short-circuit pulse.
- R8: A command that stays high for fewer than MIN_PULSE_CYC cycles never turns its gate on. A command that stays high for longer does turn its gate on.
- R9: While `rst_n` is low, and just after reset, all gates are off and `flt_drv_o` is low.
- R10: Once a gate is on, it turns off on the fourth rising edge after its command falls, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_hi_i | input | NUM_PH | Upper-switch PWM commands, bit n = phase n, 1 = on |
| cmd_lo_i | input | NUM_PH | Lower-switch PWM commands, bit n = phase n, 1 = on |
| uv_lo_i | input | 1 | Low-side driver supply undervoltage flag, 1 = low |
| uv_hi_i | input | NUM_PH | High-side bias undervoltage flags, one per phase |
| sc_i | input | 1 | Short-circuit comparator flag, 1 = tripped |
| flt_sense_i | input | 1 | Level read back from the shared fault line, 0 = line low |
| gate_hi_o | output | NUM_PH | Upper-switch gate enables |
| gate_lo_o | output | NUM_PH | Lower-switch gate enables |
| flt_drv_o | output | 1 | Fault line pull-down enable, 1 = pull the line low |

## Verification
The hardest point to reach is the restart rule: a command that stays high straight through a fault must leave its gate off once the fault clears. The bench therefore arms all gates with clean edges, holds every command high across a short-circuit pulse, an undervoltage interval, a per-phase bias loss and an external pull-down, and then watches the gates stay off. Only after that does it toggle each command and see the gate come back. The fault line is modelled as a wired-AND of the block's own pull-down and the bench's external pull-down. This is how the self-masking of the block's own fault pulse is exercised.

// File: rtl/inv_prot_pkg.sv
package inv_prot_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL    = 2'd0,
        ST_SC_FAULT  = 2'd1,
        ST_UV_FAULT  = 2'd2,
        ST_WAIT_EDGE = 2'd3
    } prot_state_e;

endpackage

// File: rtl/inv_sync.sv
module inv_sync #(
    parameter int   WIDTH   = 1,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {(STAGES*WIDTH){RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/inv_pulse_qual.sv
module inv_pulse_qual #(
    parameter int MIN_PULSE_CYC = 70
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_i,
    output logic qual_o
);

    localparam int            CW   = $clog2(MIN_PULSE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(MIN_PULSE_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          qual;
    } qual_t;

    qual_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!cmd_i) begin
            st_d.cnt  = '0;
            st_d.qual = 1'b0;
        end else if (st_q.cnt == LAST) begin
            st_d.qual = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign qual_o = st_q.qual;

endmodule

// File: rtl/inv_prot_fsm.sv
module inv_prot_fsm
    import inv_prot_pkg::*;
#(
    parameter int NUM_PH          = 3,
    parameter int FAULT_PULSE_CYC = 4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_PH-1:0] qual_hi_i,
    input  logic [NUM_PH-1:0] qual_lo_i,
    input  logic              sc_s_i,
    input  logic              uv_lo_s_i,
    input  logic [NUM_PH-1:0] uv_hi_s_i,
    input  logic              sense_s_i,
    output logic [NUM_PH-1:0] gate_hi_o,
    output logic [NUM_PH-1:0] gate_lo_o,
    output logic              flt_drv_o,
    output logic              ext_sd_o,
    output prot_state_e       state_o
);

    localparam int            FW        = $clog2(FAULT_PULSE_CYC + 1);
    localparam logic [FW-1:0] PULSE_TOP = FW'(FAULT_PULSE_CYC - 1);

    typedef struct packed {
        prot_state_e       state;
        logic [FW-1:0]     cnt;
        logic [NUM_PH-1:0] hi_prev;
        logic [NUM_PH-1:0] lo_prev;
        logic [NUM_PH-1:0] arm_hi;
        logic [NUM_PH-1:0] arm_lo;
        logic [NUM_PH-1:0] gate_hi;
        logic [NUM_PH-1:0] gate_lo;
        logic              drv;
        logic [1:0]        drv_dly;
    } fsm_t;

    fsm_t st_d, st_q;

    logic [NUM_PH-1:0] rise_hi, rise_lo;
    logic              ext_sd, block_all;

    always_comb begin
        st_d = st_q;

        // own pull-down and its synchroniser echo are not an outside request
        ext_sd  = ~sense_s_i & ~st_q.drv & ~(|st_q.drv_dly);
        rise_hi = qual_hi_i & ~st_q.hi_prev;
        rise_lo = qual_lo_i & ~st_q.lo_prev;

        st_d.hi_prev = qual_hi_i;
        st_d.lo_prev = qual_lo_i;
        st_d.drv_dly = {st_q.drv_dly[0], st_q.drv};

        unique case (st_q.state)
            ST_NORMAL, ST_WAIT_EDGE: begin
                if (sc_s_i) begin
                    st_d.state = ST_SC_FAULT;
                    st_d.cnt   = PULSE_TOP;
                end else if (uv_lo_s_i) begin
                    st_d.state = ST_UV_FAULT;
                end else if (st_q.state == ST_WAIT_EDGE && (|(rise_hi | rise_lo))) begin
                    st_d.state = ST_NORMAL;
                end
            end
            ST_SC_FAULT: begin
                if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end else if (!sc_s_i) begin
                    st_d.state = uv_lo_s_i ? ST_UV_FAULT : ST_WAIT_EDGE;
                end
            end
            ST_UV_FAULT: begin
                if (sc_s_i) begin
                    st_d.state = ST_SC_FAULT;
                    st_d.cnt   = PULSE_TOP;
                end else if (!uv_lo_s_i) begin
                    st_d.state = ST_WAIT_EDGE;
                end
            end
            default: st_d.state = ST_WAIT_EDGE;
        endcase

        block_all = sc_s_i | uv_lo_s_i | ext_sd |
                    (st_d.state == ST_SC_FAULT) | (st_d.state == ST_UV_FAULT);

        // an arm bit is set only by a fresh edge and dropped by any blocking condition
        st_d.arm_hi = block_all ? '0 : (((st_q.arm_hi & qual_hi_i) | rise_hi) & ~uv_hi_s_i);
        st_d.arm_lo = block_all ? '0 :  ((st_q.arm_lo & qual_lo_i) | rise_lo);

        st_d.gate_hi = qual_hi_i & st_d.arm_hi;
        st_d.gate_lo = qual_lo_i & st_d.arm_lo;
        st_d.drv     = (st_d.state == ST_SC_FAULT) | (st_d.state == ST_UV_FAULT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= ST_NORMAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_hi_o = st_q.gate_hi;
    assign gate_lo_o = st_q.gate_lo;
    assign flt_drv_o = st_q.drv;
    assign ext_sd_o  = ext_sd;
    assign state_o   = st_q.state;

endmodule

// File: rtl/inv_prot_ctrl.sv
module inv_prot_ctrl
    import inv_prot_pkg::*;
#(
    parameter int NUM_PH          = 3,
    parameter int SYNC_STAGES     = 2,
    parameter int MIN_PULSE_CYC   = 70,
    parameter int FAULT_PULSE_CYC = 4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_PH-1:0] cmd_hi_i,
    input  logic [NUM_PH-1:0] cmd_lo_i,
    input  logic              uv_lo_i,
    input  logic [NUM_PH-1:0] uv_hi_i,
    input  logic              sc_i,
    input  logic              flt_sense_i,
    output logic [NUM_PH-1:0] gate_hi_o,
    output logic [NUM_PH-1:0] gate_lo_o,
    output logic              flt_drv_o
);

    localparam int NCMD  = 2 * NUM_PH;
    localparam int NFLAG = NUM_PH + 2;

    logic [NCMD-1:0]   cmd_s, cmd_qual;
    logic [NFLAG-1:0]  flag_s;
    logic              sc_s, uv_lo_s, sense_s, ext_sd;
    logic [NUM_PH-1:0] uv_hi_s;
    prot_state_e       fsm_state;

    inv_sync #(.WIDTH(NCMD), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_cmd (
        .clk(clk), .rst_n(rst_n), .d_i({cmd_hi_i, cmd_lo_i}), .q_o(cmd_s)
    );

    inv_sync #(.WIDTH(NFLAG), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_flag (
        .clk(clk), .rst_n(rst_n), .d_i({uv_hi_i, uv_lo_i, sc_i}), .q_o(flag_s)
    );

    inv_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sense (
        .clk(clk), .rst_n(rst_n), .d_i(flt_sense_i), .q_o(sense_s)
    );

    assign sc_s    = flag_s[0];
    assign uv_lo_s = flag_s[1];
    assign uv_hi_s = flag_s[NFLAG-1:2];

    for (genvar c = 0; c < NCMD; c++) begin : g_qual
        inv_pulse_qual #(.MIN_PULSE_CYC(MIN_PULSE_CYC)) u_qual (
            .clk(clk), .rst_n(rst_n), .cmd_i(cmd_s[c]), .qual_o(cmd_qual[c])
        );
    end

    inv_prot_fsm #(.NUM_PH(NUM_PH), .FAULT_PULSE_CYC(FAULT_PULSE_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .qual_hi_i (cmd_qual[NCMD-1:NUM_PH]),
        .qual_lo_i (cmd_qual[NUM_PH-1:0]),
        .sc_s_i    (sc_s),
        .uv_lo_s_i (uv_lo_s),
        .uv_hi_s_i (uv_hi_s),
        .sense_s_i (sense_s),
        .gate_hi_o (gate_hi_o),
        .gate_lo_o (gate_lo_o),
        .flt_drv_o (flt_drv_o),
        .ext_sd_o  (ext_sd),
        .state_o   (fsm_state)
    );

endmodule

// File: rtl/inv_prot_ctrl_chk.sv
module inv_prot_ctrl_chk
    import inv_prot_pkg::*;
#(
    parameter int NUM_PH          = 3,
    parameter int FAULT_PULSE_CYC = 4000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sc_s,
    input logic              uv_lo_s,
    input logic [NUM_PH-1:0] uv_hi_s,
    input logic              ext_sd,
    input prot_state_e       fsm_state,
    input logic [NUM_PH-1:0] gate_hi_o,
    input logic [NUM_PH-1:0] gate_lo_o,
    input logic              flt_drv_o
);

    logic        in_sc;
    logic [31:0] sc_len_q;

    assign in_sc = (fsm_state == ST_SC_FAULT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  sc_len_q <= '0;
        else if (!in_sc)             sc_len_q <= '0;
        else if (sc_len_q != '1)     sc_len_q <= sc_len_q + 1'b1;
    end

    assert_sc_gates_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sc_s |=> (gate_hi_o == '0 && gate_lo_o == '0));

    assert_sc_min_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_sc) |-> (sc_len_q >= 32'(FAULT_PULSE_CYC)));

    assert_fault_gates_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flt_drv_o |-> (gate_hi_o == '0 && gate_lo_o == '0));

    assert_uvlo_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
        uv_lo_s |=> (flt_drv_o && gate_hi_o == '0 && gate_lo_o == '0));

    assert_uvhi_gate_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|uv_hi_s) |=> ((gate_hi_o & $past(uv_hi_s)) == '0));

    assert_fault_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flt_drv_o) |-> $past(sc_s || uv_lo_s));

    assert_ext_sd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ext_sd |=> (gate_hi_o == '0 && gate_lo_o == '0));

endmodule

bind inv_prot_ctrl inv_prot_ctrl_chk #(
    .NUM_PH(NUM_PH), .FAULT_PULSE_CYC(FAULT_PULSE_CYC)
) chk_i (
    .clk(clk), .rst_n(rst_n), .sc_s(sc_s), .uv_lo_s(uv_lo_s), .uv_hi_s(uv_hi_s),
    .ext_sd(ext_sd), .fsm_state(fsm_state), .gate_hi_o(gate_hi_o),
    .gate_lo_o(gate_lo_o), .flt_drv_o(flt_drv_o)
);

// File: tb/inv_prot_ctrl_tb_top.sv
module inv_prot_ctrl_tb_top;

    localparam int NPH  = 3;
    localparam int MINP = 5;
    localparam int PULS = 40;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NPH-1:0] cmd_hi = '0, cmd_lo = '0, uv_hi = '0;
    logic           uv_lo = 1'b0, sc = 1'b0, ext_pull = 1'b0;
    logic [NPH-1:0] gate_hi, gate_lo;
    logic           flt_drv, flt_pin;
    int             n_tests = 0, n_fail = 0;
    bit             done = 1'b0;

    always #5 clk = ~clk;

    // wired-AND fault line: low when either side pulls it
    assign flt_pin = ~(flt_drv | ext_pull);

    inv_prot_ctrl #(
        .NUM_PH(NPH), .SYNC_STAGES(2), .MIN_PULSE_CYC(MINP), .FAULT_PULSE_CYC(PULS)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_hi_i(cmd_hi), .cmd_lo_i(cmd_lo),
        .uv_lo_i(uv_lo), .uv_hi_i(uv_hi), .sc_i(sc), .flt_sense_i(flt_pin),
        .gate_hi_o(gate_hi), .gate_lo_o(gate_lo), .flt_drv_o(flt_drv)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int gates();
        return int'({gate_hi, gate_lo});
    endfunction

    task automatic restart(input logic [NPH-1:0] hi, input logic [NPH-1:0] lo);
        cmd_hi = '0; cmd_lo = '0;
        tick(8);
        cmd_hi = hi; cmd_lo = lo;
        tick(MINP + 8);
    endtask

    task automatic t_reset();
        cmd_hi = '1; cmd_lo = '1;
        tick(3);
        chk(gates() == 0, "R9 gates in reset", gates(), 0);
        chk(flt_drv == 1'b0, "R9 fault drive in reset", int'(flt_drv), 0);
        rst_n = 1'b1;
        tick(1);
        chk(gates() == 0, "R9 gates after reset", gates(), 0);
        cmd_hi = '0; cmd_lo = '0;
        tick(8);
    endtask

    task automatic t_normal();
        restart(3'b101, 3'b010);
        chk(gates() == 6'b101010, "R8 pattern A", gates(), 6'b101010);
        restart(3'b010, 3'b101);
        chk(gates() == 6'b010101, "R8 pattern B", gates(), 6'b010101);
        cmd_hi = '0; cmd_lo = '0;
        tick(3);
        chk(gates() == 6'b010101, "R10 not yet off", gates(), 6'b010101);
        tick(1);
        chk(gates() == 0, "R10 off on fourth edge", gates(), 0);
    endtask

    task automatic t_short_pulse();
        int seen = 0;
        cmd_hi[1] = 1'b1;
        tick(MINP - 2);
        cmd_hi[1] = 1'b0;
        for (int k = 0; k < 15; k++) begin
            tick(1);
            if (gate_hi[1]) seen++;
        end
        chk(seen == 0, "R8 short pulse ignored", seen, 0);
        seen = 0;
        cmd_hi[1] = 1'b1;
        tick(MINP + 2);
        cmd_hi[1] = 1'b0;
        for (int k = 0; k < 15; k++) begin
            tick(1);
            if (gate_hi[1]) seen++;
        end
        chk(seen > 0, "R8 long pulse passed", seen, 1);
    endtask

    task automatic t_sc_pulse();
        int on_cnt = 0, bad = 0;
        restart(3'b111, 3'b111);
        chk(gates() == 6'b111111, "R6 armed before short", gates(), 63);
        sc = 1'b1;
        for (int k = 0; k < 150; k++) begin
            tick(1);
            if (k == 1) sc = 1'b0;
            if (k == 2) chk(gates() == 0, "R1 gates off after short", gates(), 0);
            if (flt_drv) begin
                on_cnt++;
                if (gates() != 0) bad++;
            end
        end
        chk(on_cnt == PULS, "R2 fault pulse width", on_cnt, PULS);
        chk(bad == 0, "R3 gates during fault pulse", bad, 0);
        chk(gates() == 0, "R6 held commands after short", gates(), 0);
        chk(flt_drv == 1'b0, "R7 no self latch", int'(flt_drv), 0);
        restart(3'b001, 3'b100);
        chk(gates() == 6'b001100, "R6 restart on edge", gates(), 6'b001100);
    endtask

    task automatic t_sc_long();
        restart(3'b011, 3'b000);
        sc = 1'b1;
        tick(PULS + 20);
        chk(flt_drv == 1'b1, "R2 pulse extended", int'(flt_drv), 1);
        sc = 1'b0;
        tick(8);
        chk(flt_drv == 1'b0, "R2 pulse ends after clear", int'(flt_drv), 0);
    endtask

    task automatic t_uv_lo();
        restart(3'b110, 3'b001);
        uv_lo = 1'b1;
        tick(4);
        chk(gates() == 0, "R4 gates off in undervoltage", gates(), 0);
        tick(30);
        chk(flt_drv == 1'b1, "R4 fault held", int'(flt_drv), 1);
        uv_lo = 1'b0;
        tick(4);
        chk(flt_drv == 1'b0, "R4 fault released", int'(flt_drv), 0);
        tick(10);
        chk(gates() == 0, "R6 held after undervoltage", gates(), 0);
        restart(3'b110, 3'b001);
        chk(gates() == 6'b110001, "R6 restart after undervoltage", gates(), 6'b110001);
    endtask

    task automatic t_uv_hi();
        int drv_seen = 0;
        restart(3'b111, 3'b111);
        uv_hi[2] = 1'b1;
        for (int k = 0; k < 6; k++) begin
            tick(1);
            if (flt_drv) drv_seen++;
        end
        chk(gates() == 6'b011111, "R5 only one upper gate off", gates(), 6'b011111);
        chk(drv_seen == 0, "R5 no fault output", drv_seen, 0);
        uv_hi[2] = 1'b0;
        tick(10);
        chk(gates() == 6'b011111, "R6 upper gate held off", gates(), 6'b011111);
        cmd_hi[2] = 1'b0;
        tick(8);
        cmd_hi[2] = 1'b1;
        tick(MINP + 8);
        chk(gates() == 6'b111111, "R6 upper gate back on edge", gates(), 63);
    endtask

    task automatic t_ext();
        restart(3'b101, 3'b010);
        ext_pull = 1'b1;
        tick(4);
        chk(gates() == 0, "R7 external shutdown", gates(), 0);
        chk(flt_drv == 1'b0, "R7 no own drive", int'(flt_drv), 0);
        ext_pull = 1'b0;
        tick(10);
        chk(gates() == 0, "R6 held after shutdown", gates(), 0);
        restart(3'b101, 3'b010);
        chk(gates() == 6'b101010, "R6 restart after shutdown", gates(), 6'b101010);
    endtask

    initial begin
        t_reset();
        t_normal();
        t_short_pulse();
        t_sc_pulse();
        t_sc_long();
        t_uv_lo();
        t_uv_hi();
        t_ext();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule